// File: doc/BRIEF.md
# Complementary Pair PWM Generator with Dead-Time Insertion

This block generates pulse-width modulated waveforms on several complementary output pairs, all timed from one shared main counter so that every pair switches in lockstep. Each pair has a high-side output and a low-side output. The high-side output is active while the counter is below the compare value of the pair, and the low-side output is active for the rest of the cycle. The counter runs either as a sawtooth that wraps at the period value (edge-aligned) or as a triangle that climbs to the period value and falls back to zero (center-aligned), which gives pulses that are symmetric about the top of the count.

A programmable dead time holds back every rising edge of every output by a set number of clocks, while falling edges pass without delay. This leaves a gap in which both outputs of a pair are low, as power stages need. The period and compare inputs act as shadow registers: the block copies them into its working registers only when the counter returns to zero. A waveform that is already running therefore never sees a half-applied update. While the run input is low, the counter rests at zero, the shadow values pass straight through, and all outputs are held low.

The counter width is a parameter, so the same block gives 16-bit or 32-bit resolution.

Top module: `cpwm_dt`

## Requirements
- R1: All NCH pairs (default 3, so six outputs) are timed from one shared counter. Pairs that have equal compare values produce identical outputs in every cycle.
- R2: With `center_i` = 0 (edge-aligned) and period P, the counter runs 0, 1, ..., P, then 0 again, a cycle of P+1 clocks.
- R3: With `center_i` = 1 (center-aligned) and period P > 0, the counter runs 0, 1, ..., P, P-1, ..., 1, then 0 again, a cycle of 2P clocks. With P = 0 it stays at 0.
- R4: Bit k of the raw waveform of pair k is 1 exactly while counter < active compare k. With a compare value of 0 the high-side output never goes high. With a compare value above the counter's highest value it never falls.
- R5: With dead time D = `dead_i`, an output goes high one clock plus D clocks after its raw level has become active and stayed active, and it goes low one clock after its raw level becomes inactive. With D = 0 the two outputs of a pair are exact complements, one clock behind the counter.
- R6: The two outputs of a pair are never high in the same cycle. When D > 0, an output is never high in the cycle directly after its partner was high.
- R7: Values on `period_i` and `cmp_i` are copied into the active registers only on the clock edge that brings the counter to 0. While the counter is nonzero, the active period and compares do not change.
- R8: While `run_i` is low, the counter is forced to 0 and counts up from there, the shadow values load every cycle, and all outputs are low one clock later. When run returns, the first active edge of each output is delayed by the dead time, as in R5.
- R9: The counter width W is a parameter. A period of all ones (2^W - 1) gives a full 2^W-clock edge-aligned cycle with no overflow glitch.
- R10: After reset, all outputs are low, the counter is 0 and counts up, and the active period and compares are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run enable; low halts the counter and forces outputs low |
| center_i | input | 1 | 0 selects edge-aligned counting, 1 selects center-aligned counting |
| period_i | input | W | Shadow period value |
| cmp_i | input | NCH*W | Shadow compare values; pair k occupies bits [k*W +: W] |
| dead_i | input | DTW | Dead time in clocks applied to every rising output edge |
| pwm_hi_o | output | NCH | High-side output of each pair |
| pwm_lo_o | output | NCH | Low-side output of each pair |

## Verification
The bench builds the block with W = 8, NCH = 3 and DTW = 4. An 8-bit counter makes the all-ones period of 255 cheap to reach, so a full wrap of the counter and a compare value above its highest count can both be exercised within a few hundred cycles. Random periods are drawn mostly small, so that many center-aligned turnarounds, shadow loads and dead-time windows (0 to 6 clocks) occur in each run segment. These include pulses shorter than the dead time, which must vanish completely.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             center_i,
    input  logic [W-1:0]     period_i,
    input  logic [NCH*W-1:0] cmp_i,
    output logic [W-1:0]     cnt_o,
    output logic [NCH*W-1:0] cmp_act_o
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0]     cnt;
        cnt_dir_e         dir;
        logic [W-1:0]     per;
        logic [NCH*W-1:0] cmp;
    } tb_state_t;

    tb_state_t    s_d, s_q;
    logic [W-1:0] nxt_cnt;
    logic         at_top;

    always_comb begin
        s_d    = s_q;
        at_top = (s_q.cnt >= s_q.per);
        if (!run_i) begin
            nxt_cnt = '0;
        end else if (!center_i) begin
            nxt_cnt = at_top ? '0 : s_q.cnt + ONE;
        end else if (s_q.dir == DIR_UP && !at_top) begin
            nxt_cnt = s_q.cnt + ONE;
        end else if (s_q.cnt == '0) begin
            nxt_cnt = '0;
        end else begin
            nxt_cnt = s_q.cnt - ONE;
        end
        s_d.cnt = nxt_cnt;
        if (nxt_cnt == '0) begin
            s_d.dir = DIR_UP;
            s_d.per = period_i;
            s_d.cmp = cmp_i;
        end else if (center_i && s_q.dir == DIR_UP && at_top) begin
            s_d.dir = DIR_DOWN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, dir: DIR_UP, per: '0, cmp: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o     = s_q.cnt;
    assign cmp_act_o = s_q.cmp;

    assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (s_q.cnt == '0 && s_q.dir == DIR_UP));

    assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.per);

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) |-> (s_q.per == $past(s_q.per) && s_q.cmp == $past(s_q.cmp)));

endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
    parameter int W   = 16,
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic [W-1:0]   cnt_i,
    input  logic [W-1:0]   cmp_i,
    input  logic [DTW-1:0] dead_i,
    output logic           hi_o,
    output logic           lo_o
);

    localparam logic [DTW-1:0] DONE = DTW'(1);

    typedef struct packed {
        logic           ph;
        logic           idle;
        logic [DTW-1:0] dc;
        logic           hi;
        logic           lo;
    } pair_state_t;

    pair_state_t s_d, s_q;
    logic        raw;
    logic        settled;

    always_comb begin
        s_d     = s_q;
        raw     = (cnt_i < cmp_i);
        settled = 1'b0;
        if (!run_i) begin
            s_d.idle = 1'b1;
            s_d.ph   = 1'b0;
            s_d.dc   = '0;
            s_d.hi   = 1'b0;
            s_d.lo   = 1'b0;
        end else begin
            s_d.idle = 1'b0;
            s_d.ph   = raw;
            if (s_q.idle || raw != s_q.ph) begin
                s_d.dc  = (dead_i == '0) ? '0 : dead_i - DONE;
                settled = (dead_i == '0);
            end else begin
                if (s_q.dc != '0) s_d.dc = s_q.dc - DONE;
                settled = (s_q.dc == '0);
            end
            s_d.hi = raw && settled;
            s_d.lo = !raw && settled;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: 1'b0, idle: 1'b1, dc: '0, hi: 1'b0, lo: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign hi_o = s_q.hi;
    assign lo_o = s_q.lo;

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.hi && s_q.lo));

    assert_dead_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(s_q.hi) || $past(s_q.lo)) && dead_i != '0 && $stable(dead_i))
            |-> !($past(s_q.hi) && s_q.lo) && !($past(s_q.lo) && s_q.hi));

    assert_off_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!s_q.hi && !s_q.lo));

endmodule

// File: rtl/cpwm_dt.sv
module cpwm_dt
    import cpwm_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 3,
    parameter int DTW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             center_i,
    input  logic [W-1:0]     period_i,
    input  logic [NCH*W-1:0] cmp_i,
    input  logic [DTW-1:0]   dead_i,
    output logic [NCH-1:0]   pwm_hi_o,
    output logic [NCH-1:0]   pwm_lo_o
);

    logic [W-1:0]     cnt;
    logic [NCH*W-1:0] cmp_act;

    cpwm_timebase #(.W(W), .NCH(NCH)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .center_i  (center_i),
        .period_i  (period_i),
        .cmp_i     (cmp_i),
        .cnt_o     (cnt),
        .cmp_act_o (cmp_act)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_pair
        cpwm_pair #(.W(W), .DTW(DTW)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run_i),
            .cnt_i  (cnt),
            .cmp_i  (cmp_act[c*W +: W]),
            .dead_i (dead_i),
            .hi_o   (pwm_hi_o[c]),
            .lo_o   (pwm_lo_o[c])
        );
    end

    assert_pairs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_hi_o & pwm_lo_o) == '0);

endmodule

// File: tb/sim_cpwm_dt.sv
module sim_cpwm_dt;

    localparam int W   = 8;
    localparam int NCH = 3;
    localparam int DTW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_i = 1'b0;
    logic             center_i = 1'b0;
    logic [W-1:0]     period_i = '0;
    logic [NCH*W-1:0] cmp_i = '0;
    logic [DTW-1:0]   dead_i = '0;
    logic [NCH-1:0]   pwm_hi_o;
    logic [NCH-1:0]   pwm_lo_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cpwm_dt #(.W(W), .NCH(NCH), .DTW(DTW)) u0 (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .center_i(center_i),
        .period_i(period_i), .cmp_i(cmp_i), .dead_i(dead_i),
        .pwm_hi_o(pwm_hi_o), .pwm_lo_o(pwm_lo_o)
    );

    // reference model state
    logic [W-1:0]   m_cnt = '0;
    logic           m_up  = 1'b1;
    logic [W-1:0]   m_per = '0;
    logic [W-1:0]   m_cmp [NCH];
    logic [15:0]    m_hh  [NCH];
    logic [15:0]    m_hl  [NCH];
    logic [NCH-1:0] exp_hi = '0;
    logic [NCH-1:0] exp_lo = '0;
    string          exp_tag = "R10";

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [W-1:0] n;
        logic         top;
        logic         loaded;
        top = (m_cnt >= m_per);
        for (int c = 0; c < NCH; c++) begin
            logic raw;
            logic h, l;
            raw = (m_cnt < m_cmp[c]);
            m_hh[c] = {m_hh[c][14:0], run_i && raw};
            m_hl[c] = {m_hl[c][14:0], run_i && !raw};
            h = 1'b1; l = 1'b1;
            for (int j = 0; j <= int'(dead_i); j++) begin
                h = h && m_hh[c][j];
                l = l && m_hl[c][j];
            end
            exp_hi[c] = h;
            exp_lo[c] = l;
        end
        if (!run_i) n = '0;
        else if (!center_i) n = top ? '0 : m_cnt + 8'd1;
        else if (m_up && !top) n = m_cnt + 8'd1;
        else if (m_cnt == '0) n = '0;
        else n = m_cnt - 8'd1;
        loaded = 1'b0;
        if (n == '0) begin
            m_up = 1'b1;
            loaded = (m_per != period_i);
            m_per = period_i;
            for (int c = 0; c < NCH; c++) begin
                if (m_cmp[c] != cmp_i[c*W +: W]) loaded = 1'b1;
                m_cmp[c] = cmp_i[c*W +: W];
            end
        end else if (center_i && m_up && top) begin
            m_up = 1'b0;
        end
        m_cnt = n;
        if (!run_i) exp_tag = "R8";
        else if (loaded) exp_tag = "R7";
        else if (center_i) exp_tag = "R3";
        else exp_tag = "R2";
    endtask

    // one clock: drive is already done by caller; step model, move to next negedge, compare
    task automatic cycle();
        model_step();
        @(negedge clk);
        check({exp_tag, " R4 hi"}, 32'(pwm_hi_o), 32'(exp_hi));
        check("R5 lo", 32'(pwm_lo_o), 32'(exp_lo));
        check("R6 overlap", 32'(pwm_hi_o & pwm_lo_o), 32'd0);
    endtask

    task automatic set_cmp(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        cmp_i = {c, b, a};
    endtask

    task automatic idle(input int n);
        run_i = 1'b0;
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        #(4ns * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int hi_cnt;
        for (int c = 0; c < NCH; c++) begin
            m_cmp[c] = '0; m_hh[c] = '0; m_hl[c] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10 hi", 32'(pwm_hi_o), 32'd0);
        check("R10 lo", 32'(pwm_lo_o), 32'd0);

        // R10: outputs of a fresh start follow the reset counter state (edge, P=5)
        center_i = 1'b0; period_i = 8'd5; set_cmp(8'd2, 8'd3, 8'd0); dead_i = 4'd0;
        idle(2);
        run_i = 1'b1;
        for (int i = 0; i < 30; i++) cycle();

        // R1: equal compares give identical pairs
        idle(8);
        center_i = 1'b1; period_i = 8'd7; set_cmp(8'd4, 8'd4, 8'd4); dead_i = 4'd2;
        idle(4);
        run_i = 1'b1;
        for (int i = 0; i < 40; i++) begin
            cycle();
            check("R1 same hi", 32'(pwm_hi_o == '0 || pwm_hi_o == '1), 32'd1);
        end

        // R4: compare 0 never drives high, compare above top never drops
        idle(8);
        center_i = 1'b0; period_i = 8'd9; set_cmp(8'd0, 8'd10, 8'd5); dead_i = 4'd1;
        idle(4);
        run_i = 1'b1;
        for (int i = 0; i < 40; i++) begin
            cycle();
            check("R4 cmp0", 32'(pwm_hi_o[0]), 32'd0);
            if (i >= 3) check("R4 cmp>P", 32'(pwm_hi_o[1]), 32'd1);
        end

        // R9: full-width period in edge mode, count high cycles of pair 0 over 256 clocks
        idle(8);
        center_i = 1'b0; period_i = 8'hFF; set_cmp(8'd100, 8'd255, 8'd1); dead_i = 4'd0;
        idle(4);
        run_i = 1'b1;
        for (int i = 0; i < 10; i++) cycle();
        hi_cnt = 0;
        for (int i = 0; i < 256; i++) begin
            cycle();
            if (pwm_hi_o[0]) hi_cnt++;
        end
        check("R9 duty 100/256", 32'(hi_cnt), 32'd100);

        // R5: pulse shorter than the dead time vanishes
        idle(8);
        center_i = 1'b0; period_i = 8'd12; set_cmp(8'd2, 8'd11, 8'd6); dead_i = 4'd4;
        idle(6);
        run_i = 1'b1;
        for (int i = 0; i < 60; i++) begin
            cycle();
            check("R5 short pulse", 32'(pwm_hi_o[0]), 32'd0);
        end

        // random segments with mid-run shadow updates (R2, R3, R5, R7, R8)
        for (int seg = 0; seg < 40; seg++) begin
            int len;
            idle(8);
            center_i = 1'($urandom_range(0, 1));
            dead_i   = 4'($urandom_range(0, 6));
            period_i = ($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom_range(0, 20));
            set_cmp(8'($urandom_range(0, 22)), 8'($urandom_range(0, 22)), 8'($urandom_range(0, 22)));
            idle(8);
            run_i = 1'b1;
            len = $urandom_range(150, 400);
            for (int i = 0; i < len; i++) begin
                if ($urandom_range(0, 29) == 0) begin
                    period_i = 8'($urandom_range(0, 20));
                    set_cmp(8'($urandom_range(0, 22)), 8'($urandom_range(0, 22)), 8'($urandom_range(0, 22)));
                end
                cycle();
            end
        end

        // R8: after run drops, everything is low one clock later
        run_i = 1'b0;
        cycle();
        check("R8 hi off", 32'(pwm_hi_o), 32'd0);
        check("R8 lo off", 32'(pwm_lo_o), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule